// File: doc/BRIEF.md
# Pad-Sharing GPIO Controller with Two Alternate Sources

This block sits between a bank of I/O pads and the rest of the chip. It has 16 or 32 channels. Software programs each channel through an APB slave port. A channel can act as plain general-purpose I/O, backed by a data-out register and a synchronized data-in register. It can instead hand its pad to one of two on-chip peripherals, called source A and source B. The choice is made per channel.

For every pad the block drives output data, an output enable, an input enable, a weak pull-up, a weak pull-down and a high-drive control. Each channel can raise a level-sensitive interrupt whose active level is programmable. All active channels are ORed into one interrupt line. A functional test input hands the pad data, output enable and input enable to external test logic, whatever the registers hold.

Top module: `apb_gpio_mux`

## Requirements
- R1: After the asynchronous reset every register reads zero. pad_oe, pad_ie, pad_out, pad_pu, pad_pd, pad_hd and irq are all zero.
- R2: These word offsets are read/write and read back the last written value: 0x000 data out, 0x008 output enable, 0x00C input enable, 0x010 mode (1 = alternate), 0x014 source select (1 = B), 0x018 pull-up, 0x01C pull-down, 0x020 high drive, 0x024 interrupt enable, 0x028 polarity (1 = active high). Bit n of each register controls channel n.
- R3: Reads from any other offset return zero, and so do reads where paddr[1:0] is not 00. Writes to the read-only offsets 0x004 and 0x02C change nothing.
- R4: A register is written only in a cycle where psel, penable and pwrite are all high. pready is always 1 and pslverr is always 0.
- R5: Offset 0x004 returns pad_in as it was sampled two clock edges earlier, through a two-flop synchronizer.
- R6: When a channel's mode bit is 0 and test_mode is low, its pad_out, pad_oe and pad_ie come from the data out, output enable and input enable registers.
- R7: When a channel's mode bit is 1 and test_mode is low, its pad_out, pad_oe and pad_ie come from source A when its select bit is 0, and from source B when the bit is 1.
- R8: pad_pu, pad_pd and pad_hd always equal the pull-up, pull-down and high-drive registers. Mode, source select and test_mode do not affect them.
- R9: While test_mode is high, pad_out, pad_oe and pad_ie equal test_out, test_oe and test_ie on every channel.
- R10: A channel is active when its interrupt-enable bit is 1 and its synchronized input equals its polarity bit. Offset 0x02C reads the active bits. irq is the OR of those bits. irq clears once the input leaves the active level, or in the cycle after the enable bits are written to zero.
- R11: alt_in equals pad_in combinationally, with no synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | APB clock |
| presetn | input | 1 | Asynchronous reset, active low |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write strobe |
| paddr | input | AW | APB byte address |
| pwdata | input | NCH | APB write data |
| prdata | output | NCH | APB read data |
| pready | output | 1 | Always ready |
| pslverr | output | 1 | Never an error |
| pad_in | input | NCH | Level received from the pads |
| pad_out | output | NCH | Data driven to the pads |
| pad_oe | output | NCH | Pad output enables |
| pad_ie | output | NCH | Pad input enables |
| pad_pu | output | NCH | Weak pull-up controls |
| pad_pd | output | NCH | Weak pull-down controls |
| pad_hd | output | NCH | High-drive controls |
| alt_a_out | input | NCH | Source A output data |
| alt_a_oe | input | NCH | Source A output enables |
| alt_a_ie | input | NCH | Source A input enables |
| alt_b_out | input | NCH | Source B output data |
| alt_b_oe | input | NCH | Source B output enables |
| alt_b_ie | input | NCH | Source B input enables |
| alt_in | output | NCH | Raw pad level passed to the peripherals |
| test_mode | input | 1 | Functional test takeover |
| test_out | input | NCH | Test-logic pad data |
| test_oe | input | NCH | Test-logic output enables |
| test_ie | input | NCH | Test-logic input enables |
| irq | output | 1 | Combined level-sensitive interrupt |

## Verification
Pad controls and alt_in are combinational from registers and inputs. The bench checks them at the falling edge right after the access-phase rising edge of the last write, or right after it changes an input. The data-in readback, the status register and irq lag pad_in by two rising edges. The bench therefore holds pad_in for two full cycles before it reads or compares them. A register write shows up at the next falling edge. So the check that a zero enable write clears irq is taken one edge after the access phase.

// File: rtl/apb_gpio_mux.sv
module apb_gpio_mux #(
  parameter int NCH = 32,
  parameter int AW  = 10
) (
  input  logic           pclk,
  input  logic           presetn,
  input  logic           psel,
  input  logic           penable,
  input  logic           pwrite,
  input  logic [AW-1:0]  paddr,
  input  logic [NCH-1:0] pwdata,
  output logic [NCH-1:0] prdata,
  output logic           pready,
  output logic           pslverr,
  input  logic [NCH-1:0] pad_in,
  output logic [NCH-1:0] pad_out,
  output logic [NCH-1:0] pad_oe,
  output logic [NCH-1:0] pad_ie,
  output logic [NCH-1:0] pad_pu,
  output logic [NCH-1:0] pad_pd,
  output logic [NCH-1:0] pad_hd,
  input  logic [NCH-1:0] alt_a_out,
  input  logic [NCH-1:0] alt_a_oe,
  input  logic [NCH-1:0] alt_a_ie,
  input  logic [NCH-1:0] alt_b_out,
  input  logic [NCH-1:0] alt_b_oe,
  input  logic [NCH-1:0] alt_b_ie,
  output logic [NCH-1:0] alt_in,
  input  logic           test_mode,
  input  logic [NCH-1:0] test_out,
  input  logic [NCH-1:0] test_oe,
  input  logic [NCH-1:0] test_ie,
  output logic           irq
);
  localparam int IW = AW - 2;
  localparam logic [IW-1:0] W_DOUT = IW'(0),  W_DIN  = IW'(1),  W_OE   = IW'(2),
                            W_IE   = IW'(3),  W_MODE = IW'(4),  W_ASEL = IW'(5),
                            W_PU   = IW'(6),  W_PD   = IW'(7),  W_HD   = IW'(8),
                            W_IEN  = IW'(9),  W_POL  = IW'(10), W_STAT = IW'(11);

  logic [NCH-1:0] dout_r, oe_r, ie_r, mode_r, asel_r, pu_r, pd_r, hd_r, ien_r, pol_r;
  logic [NCH-1:0] sync1_r, sync2_r;
  logic [NCH-1:0] src_out, src_oe, src_ie, active;
  logic [IW-1:0]  widx;
  logic           aligned, wr;

  assign widx    = paddr[AW-1:2];
  assign aligned = (paddr[1:0] == 2'b00);
  assign wr      = psel && penable && pwrite && aligned;
  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      dout_r <= '0; oe_r <= '0; ie_r <= '0; mode_r <= '0; asel_r <= '0;
      pu_r   <= '0; pd_r <= '0; hd_r <= '0; ien_r  <= '0; pol_r  <= '0;
    end else if (wr) begin
      case (widx)
        W_DOUT: dout_r <= pwdata;
        W_OE:   oe_r   <= pwdata;
        W_IE:   ie_r   <= pwdata;
        W_MODE: mode_r <= pwdata;
        W_ASEL: asel_r <= pwdata;
        W_PU:   pu_r   <= pwdata;
        W_PD:   pd_r   <= pwdata;
        W_HD:   hd_r   <= pwdata;
        W_IEN:  ien_r  <= pwdata;
        W_POL:  pol_r  <= pwdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      sync1_r <= '0;
      sync2_r <= '0;
    end else begin
      sync1_r <= pad_in;
      sync2_r <= sync1_r;
    end
  end

  assign src_out = (asel_r & alt_b_out) | (~asel_r & alt_a_out);
  assign src_oe  = (asel_r & alt_b_oe)  | (~asel_r & alt_a_oe);
  assign src_ie  = (asel_r & alt_b_ie)  | (~asel_r & alt_a_ie);

  assign pad_out = test_mode ? test_out : ((mode_r & src_out) | (~mode_r & dout_r));
  assign pad_oe  = test_mode ? test_oe  : ((mode_r & src_oe)  | (~mode_r & oe_r));
  assign pad_ie  = test_mode ? test_ie  : ((mode_r & src_ie)  | (~mode_r & ie_r));
  assign pad_pu  = pu_r;
  assign pad_pd  = pd_r;
  assign pad_hd  = hd_r;
  assign alt_in  = pad_in;

  assign active = ien_r & ~(sync2_r ^ pol_r);
  assign irq    = |active;

  always_comb begin
    prdata = '0;
    if (aligned) begin
      case (widx)
        W_DOUT: prdata = dout_r;
        W_DIN:  prdata = sync2_r;
        W_OE:   prdata = oe_r;
        W_IE:   prdata = ie_r;
        W_MODE: prdata = mode_r;
        W_ASEL: prdata = asel_r;
        W_PU:   prdata = pu_r;
        W_PD:   prdata = pd_r;
        W_HD:   prdata = hd_r;
        W_IEN:  prdata = ien_r;
        W_POL:  prdata = pol_r;
        W_STAT: prdata = active;
        default: prdata = '0;
      endcase
    end
  end

  logic [1:0] since_rst;
  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) since_rst <= '0;
    else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
  end

  // R2
  dout_write_chk: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && penable && pwrite && paddr == '0) |=> (pad_out == $past(pwdata)) || test_mode || (mode_r != '0));

  // R5
  sync_delay_chk: assert property (@(posedge pclk) disable iff (!presetn)
    (since_rst == 2'd2) |-> (sync2_r == $past(pad_in, 2)));

  // R9
  test_override_chk: assert property (@(posedge pclk) disable iff (!presetn)
    test_mode |-> (pad_oe == test_oe && pad_ie == test_ie && pad_out == test_out));

  // R10
  irq_mask_chk: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && penable && pwrite && paddr == {W_IEN, 2'b00} && pwdata == '0) |=> !irq);

  // R4
  no_setup_write_chk: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && !penable) |=> $stable(dout_r) && $stable(ien_r) && $stable(mode_r));
endmodule

// File: tb/apb_gpio_mux_tb.sv
module apb_gpio_mux_tb_top;
  localparam int NCH = 32;
  localparam int AW  = 10;
  localparam time CLK_PERIOD = 10;

  logic pclk = 0, presetn = 0, psel = 0, penable = 0, pwrite = 0;
  logic [AW-1:0] paddr = '0;
  logic [NCH-1:0] pwdata = '0, prdata, pad_in = '0;
  logic pready, pslverr, test_mode = 0, irq;
  logic [NCH-1:0] pad_out, pad_oe, pad_ie, pad_pu, pad_pd, pad_hd, alt_in;
  logic [NCH-1:0] a_out = '0, a_oe = '0, a_ie = '0, b_out = '0, b_oe = '0, b_ie = '0;
  logic [NCH-1:0] t_out = '0, t_oe = '0, t_ie = '0;
  int checks = 0, fails = 0;
  logic [NCH-1:0] m [0:11];

  always #(CLK_PERIOD/2) pclk = ~pclk;

  apb_gpio_mux #(.NCH(NCH), .AW(AW)) dut_i (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_ie(pad_ie),
    .pad_pu(pad_pu), .pad_pd(pad_pd), .pad_hd(pad_hd),
    .alt_a_out(a_out), .alt_a_oe(a_oe), .alt_a_ie(a_ie),
    .alt_b_out(b_out), .alt_b_oe(b_oe), .alt_b_ie(b_ie), .alt_in(alt_in),
    .test_mode(test_mode), .test_out(t_out), .test_oe(t_oe), .test_ie(t_ie), .irq(irq));

  task automatic check(string req, logic [NCH-1:0] act, logic [NCH-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apb_write(int off, logic [NCH-1:0] d);
    @(negedge pclk); psel = 1; pwrite = 1; penable = 0; paddr = AW'(off); pwdata = d;
    @(negedge pclk); penable = 1;
    @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
    if (off % 4 == 0 && off / 4 < 12 && off != 'h4 && off != 'h2C) m[off/4] = d;
  endtask

  task automatic apb_read(int off, output logic [NCH-1:0] d);
    @(negedge pclk); psel = 1; pwrite = 0; penable = 0; paddr = AW'(off);
    @(negedge pclk); penable = 1; #1 d = prdata;
    @(negedge pclk); psel = 0; penable = 0;
  endtask

  function automatic logic [NCH-1:0] pick(logic [NCH-1:0] gp, logic [NCH-1:0] a,
                                          logic [NCH-1:0] b, logic [NCH-1:0] t);
    logic [NCH-1:0] r;
    if (test_mode) return t;
    for (int i = 0; i < NCH; i++) r[i] = m[4][i] ? (m[5][i] ? b[i] : a[i]) : gp[i];
    return r;
  endfunction

  function automatic logic [NCH-1:0] exp_active(logic [NCH-1:0] pin);
    return m[9] & ~(pin ^ m[10]);
  endfunction

  task automatic check_pads(string tag);
    check({tag, " R6/R7/R9 pad_out"}, pad_out, pick(m[0], a_out, b_out, t_out));
    check({tag, " R6/R7/R9 pad_oe"},  pad_oe,  pick(m[2], a_oe, b_oe, t_oe));
    check({tag, " R6/R7/R9 pad_ie"},  pad_ie,  pick(m[3], a_ie, b_ie, t_ie));
    check({tag, " R8 pu"}, pad_pu, m[6]);
    check({tag, " R8 pd"}, pad_pd, m[7]);
    check({tag, " R8 hd"}, pad_hd, m[8]);
    check({tag, " R11 alt_in"}, alt_in, pad_in);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [NCH-1:0] rd;
    int seed;
    seed = 7;
    void'($urandom(seed));
    for (int i = 0; i < 12; i++) m[i] = '0;
    #(CLK_PERIOD * 2 + 2);
    // R1 reset state
    check("R1 pad_oe", pad_oe, '0); check("R1 pad_ie", pad_ie, '0);
    check("R1 irq", NCH'(irq), '0); check("R1 pu", pad_pu, '0);
    presetn = 1;
    for (int i = 0; i < 12; i++) begin apb_read(i*4, rd); check("R1 reg", rd, '0); end
    check("R4 pready", NCH'(pready), 1); check("R4 pslverr", NCH'(pslverr), 0);

    // R2 readback
    for (int i = 0; i < 11; i++) begin
      if (i == 1) continue;
      apb_write(i*4, $urandom);
      apb_read(i*4, rd); check("R2 readback", rd, m[i]);
    end

    // R3 unmapped, unaligned, read-only
    apb_read('h030, rd); check("R3 unmapped", rd, '0);
    apb_read('h3FC, rd); check("R3 unmapped top", rd, '0);
    apb_read('h001, rd); check("R3 unaligned", rd, '0);
    apb_write('h004, '1); apb_write('h02C, '1);
    for (int i = 0; i < 11; i++) begin
      if (i == 1) continue;
      apb_read(i*4, rd); check("R3 ro write no effect", rd, m[i]);
    end

    // R4 setup-only and read accesses do not write
    @(negedge pclk); psel = 1; pwrite = 1; penable = 0; paddr = '0; pwdata = ~m[0];
    @(negedge pclk); psel = 0; pwrite = 0;
    @(negedge pclk); psel = 1; pwrite = 0; penable = 1; paddr = '0;
    @(negedge pclk); psel = 0; penable = 0;
    apb_read(0, rd); check("R4 no write", rd, m[0]);

    // R5/R10 directed interrupt cases
    apb_write('h024, 32'h0000_0003); apb_write('h028, 32'h0000_0001);
    @(negedge pclk); pad_in = 32'h0000_0003;
    @(negedge pclk); @(negedge pclk);
    check("R10 irq ch1 low inactive ch0 high active", NCH'(irq), 1);
    apb_read('h02C, rd); check("R10 status", rd, 32'h1);
    apb_read('h004, rd); check("R5 data in", rd, 32'h3);
    @(negedge pclk); pad_in = 32'h0000_0000;
    @(negedge pclk); check("R5 one edge still old", NCH'(irq), 1);
    @(negedge pclk); check("R10 ch1 now low active", NCH'(irq), 1);
    apb_read('h02C, rd); check("R10 status ch1", rd, 32'h2);
    apb_write('h028, 32'h0000_0003);
    check("R10 leave level", NCH'(irq), 0);
    apb_write('h028, 32'h0); check("R10 active again", NCH'(irq), 1);
    apb_write('h024, 32'h0); check("R10 disable clears", NCH'(irq), 0);

    // random mix
    for (int it = 0; it < 60; it++) begin
      apb_write('h000, $urandom); apb_write('h008, $urandom); apb_write('h00C, $urandom);
      apb_write('h010, $urandom); apb_write('h014, $urandom); apb_write('h018, $urandom);
      apb_write('h01C, $urandom); apb_write('h020, $urandom); apb_write('h024, $urandom);
      apb_write('h028, $urandom);
      @(negedge pclk);
      a_out = $urandom; a_oe = $urandom; a_ie = $urandom;
      b_out = $urandom; b_oe = $urandom; b_ie = $urandom;
      t_out = $urandom; t_oe = $urandom; t_ie = $urandom;
      test_mode = ($urandom % 3 == 0);
      pad_in = $urandom;
      #1 check_pads("rand");
      @(negedge pclk); @(negedge pclk);
      check("R10 irq rand", NCH'(irq), NCH'(|exp_active(pad_in)));
      apb_read('h02C, rd); check("R10 status rand", rd, exp_active(pad_in));
      apb_read('h004, rd); check("R5 data in rand", rd, pad_in);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule